// File: doc/BRIEF.md
# Dual-Port Mailbox Register Bridge

This block joins two processors that share one clock: a host, which owns the control settings, and a parasite. The two exchange bytes through four mailbox channels. Each channel has one byte path from host to parasite and a separate path from parasite to host. Each processor sees eight byte locations. An even offset is the status of a channel and the next odd offset is its data. A write to a data location sends a byte toward the other side. A read of a data location takes the byte that waits there.

A six-bit control field sits in the low bits of the host's first status location. It holds the reset line for the parasite, the switch that makes channel 3 two bytes deep, and the enables for three interrupt lines. The parasite IRQ and NMI are raised by host traffic. The host IRQ is raised by parasite traffic on channel 4. Every interrupt is a level that stays high until the byte that caused it has been read. Reset is asynchronous and active low, and its release passes through a two-stage synchronizer.

Top module: `mbox_bridge`

## Requirements
- R1: On each side, offset 2k addresses the status of channel k+1 and offset 2k+1 addresses its data (k = 0..3). A data write pushes a byte toward the other side, and a data read pops the byte sent from the other side.
- R2: After reset, every path is empty. The host status at offset 0 reads 8'h60, the other host and parasite status locations read 8'h40, the data locations read 8'h00, p_rst_n is 1 and all interrupt lines are 0.
- R3: Status bit 7 is 1 exactly when the path toward the reading side of that channel holds at least one byte.
- R4: Status bit 6 is 1 exactly when the path leaving the reading side of that channel can take another byte.
- R5: A host write to offset 0 loads bits 5..0 into the control field: bit 5 releases the parasite from reset, bit 4 makes channel 3 two bytes deep, bit 3 enables the NMI from channel 3, bit 2 enables the parasite IRQ from channel 4, bit 1 enables the parasite IRQ from channel 1, and bit 0 enables the host IRQ from channel 4. The host reads the field back in bits 5..0 of offset 0. All other status bits 5..0 read 0, and parasite writes to status locations have no effect.
- R6: p_irq is high while bit 1 is set and a host byte waits in channel 1.
- R7: p_nmi is high while bit 3 is set and a host byte waits in channel 3.
- R8: p_irq is also high while bit 2 is set and a host byte waits in channel 4.
- R9: h_irq is high while bit 0 is set and a parasite byte waits in channel 4.
- R10: While bit 4 is set, both paths of channel 3 hold up to two bytes and deliver them in order. Every other path, and channel 3 while bit 4 is clear, holds one byte.
- R11: A write to a full path is ignored. Fullness and emptiness are judged on the state before the clock edge.
- R12: A read of an empty path returns the byte that was last read from it (0 after reset) and leaves the flags unchanged.
- R13: p_rst_n equals control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (a data read pops) |
| h_addr | input | 3 | Host byte offset |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for h_addr, combinational |
| p_wr | input | 1 | Parasite write strobe |
| p_rd | input | 1 | Parasite read strobe (a data read pops) |
| p_addr | input | 3 | Parasite byte offset |
| p_wdata | input | 8 | Parasite write data |
| p_rdata | output | 8 | Parasite read data for p_addr, combinational |
| h_irq | output | 1 | Interrupt to the host |
| p_irq | output | 1 | Interrupt to the parasite |
| p_nmi | output | 1 | Non-maskable interrupt to the parasite |
| p_rst_n | output | 1 | Active-low reset to the parasite |

## Verification
The read data follows the offset in the same cycle with no register in between. Every write, pop and control update, and every flag and interrupt level that follows from it, becomes visible in the first cycle after the clock edge that samples the strobe. The bench changes its inputs on the falling edge and compares every output a quarter period later, before the next rising edge. Its queue model advances only after that rising edge, so each comparison sees exactly the state one edge after the stimulus.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NCH      = 4;
  localparam int DW       = 8;
  localparam int AW       = 3;
  localparam int CHW      = 2;
  localparam int BUF_CH   = 2;   // zero-based index of channel 3
  localparam int ST_AVAIL = 7;
  localparam int ST_ROOM  = 6;
  localparam int CTLW     = 6;

  typedef struct packed {
    logic run_n;      // bit 5: parasite out of reset
    logic deep3;      // bit 4: channel 3 two-deep
    logic nmi_en3;    // bit 3
    logic pirq_en4;   // bit 2
    logic pirq_en1;   // bit 1
    logic hirq_en4;   // bit 0
  } ctl_t;

  localparam ctl_t CTL_RESET = '{run_n: 1'b1, default: 1'b0};
endpackage

// File: rtl/mbox_path.sv
module mbox_path #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic [CW-1:0] cap,
  output logic [DW-1:0] dout,
  output logic          avail,
  output logic          room
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] head;
  logic [DW-1:0] last_q, last_d;
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          full, empty, push_ok, pop_ok;

  assign empty   = (count_q == '0);
  assign full    = (count_q >= cap);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    head = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_ptr_q == PW'(i)) head = mem_q[i];
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    last_d   = last_q;
    if (push_ok)
      wr_ptr_d = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      last_d   = head;
    end
    case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      last_q   <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (push_ok && wr_ptr_q == PW'(i)) mem_q[i] <= din;
  end

  assign dout  = empty ? last_q : head;
  assign avail = !empty;
  assign room  = !full;

  // R11: a write into a full path, with no pop, leaves the occupancy alone
  p_full_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count_q));
  // R12: popping an empty path keeps the last delivered byte
  p_empty_read_keeps_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(last_q));
  // R10: occupancy never passes the built depth
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CTLW-1:0] wdata,
  input  logic [NCH-1:0]  h2p_avail,
  input  logic [NCH-1:0]  p2h_avail,
  output ctl_t            ctl,
  output logic            p_irq,
  output logic            p_nmi,
  output logic            h_irq,
  output logic            p_rst_n
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = ctl_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign ctl     = ctl_q;
  assign p_irq   = (ctl_q.pirq_en1 && h2p_avail[0]) || (ctl_q.pirq_en4 && h2p_avail[3]);
  assign p_nmi   = ctl_q.nmi_en3 && h2p_avail[BUF_CH];
  assign h_irq   = ctl_q.hirq_en4 && p2h_avail[3];
  assign p_rst_n = ctl_q.run_n;

  // R13: the parasite reset line follows the written bit one edge later
  p_prst_follows_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (p_rst_n == $past(wdata[5])));
  // R7: the NMI only rises on new channel 3 data or a control write
  p_nmi_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_nmi) |-> ($rose(h2p_avail[BUF_CH]) || $past(wr_en)));
  // R9: the host IRQ only rises on new channel 4 data or a control write
  p_hirq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_irq) |-> ($rose(p2h_avail[3]) || $past(wr_en)));
  // R6 R8: the parasite IRQ only rises on channel 1 or 4 data or a control write
  p_pirq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_irq) |-> ($rose(h2p_avail[0]) || $rose(h2p_avail[3]) || $past(wr_en)));
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_pkg::*;
#(
  parameter int BUF_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          p_wr,
  input  logic          p_rd,
  input  logic [AW-1:0] p_addr,
  input  logic [DW-1:0] p_wdata,
  output logic [DW-1:0] p_rdata,
  output logic          h_irq,
  output logic          p_irq,
  output logic          p_nmi,
  output logic          p_rst_n
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic           h_is_data, p_is_data;
  logic [CHW-1:0] h_ch, p_ch;
  logic           ctl_wr;
  ctl_t           ctl;

  assign h_is_data = h_addr[0];
  assign p_is_data = p_addr[0];
  assign h_ch      = h_addr[AW-1:1];
  assign p_ch      = p_addr[AW-1:1];
  assign ctl_wr    = h_wr && (h_addr == '0);

  logic [DW-1:0]  h2p_dout  [NCH];
  logic [DW-1:0]  p2h_dout  [NCH];
  logic [NCH-1:0] h2p_avail, h2p_room, p2h_avail, p2h_room;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int D  = (c == BUF_CH) ? BUF_DEPTH : 1;
    localparam int CW = $clog2(D + 1);
    logic [CW-1:0] cap;
    logic h_push, h_pop, p_push, p_pop;

    assign cap    = (c == BUF_CH && ctl.deep3) ? CW'(D) : CW'(1);
    assign h_push = h_wr && h_is_data && (h_ch == CHW'(c));
    assign p_pop  = p_rd && p_is_data && (p_ch == CHW'(c));
    assign p_push = p_wr && p_is_data && (p_ch == CHW'(c));
    assign h_pop  = h_rd && h_is_data && (h_ch == CHW'(c));

    mbox_path #(.DW(DW), .DEPTH(D)) u_h2p (
      .clk(clk), .rst_n(rst_i_n), .push(h_push), .din(h_wdata), .pop(p_pop),
      .cap(cap), .dout(h2p_dout[c]), .avail(h2p_avail[c]), .room(h2p_room[c]));

    mbox_path #(.DW(DW), .DEPTH(D)) u_p2h (
      .clk(clk), .rst_n(rst_i_n), .push(p_push), .din(p_wdata), .pop(h_pop),
      .cap(cap), .dout(p2h_dout[c]), .avail(p2h_avail[c]), .room(p2h_room[c]));
  end

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .wr_en(ctl_wr), .wdata(h_wdata[CTLW-1:0]),
    .h2p_avail(h2p_avail), .p2h_avail(p2h_avail), .ctl(ctl),
    .p_irq(p_irq), .p_nmi(p_nmi), .h_irq(h_irq), .p_rst_n(p_rst_n));

  always_comb begin
    if (h_is_data) begin
      h_rdata = p2h_dout[h_ch];
    end else begin
      h_rdata = '0;
      h_rdata[ST_AVAIL] = p2h_avail[h_ch];
      h_rdata[ST_ROOM]  = h2p_room[h_ch];
      if (h_ch == '0) h_rdata[CTLW-1:0] = ctl;
    end
  end

  always_comb begin
    if (p_is_data) begin
      p_rdata = h2p_dout[p_ch];
    end else begin
      p_rdata = '0;
      p_rdata[ST_AVAIL] = h2p_avail[p_ch];
      p_rdata[ST_ROOM]  = p2h_room[p_ch];
    end
  end

  // R3: channel 1 data seen by the parasite always came from a host write
  p_avail_from_host_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(h2p_avail[0]) |-> $past(h_wr && h_addr == 3'd1));
endmodule

// File: tb/mbox_bridge_bench.sv
module mbox_bridge_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       h_wr, h_rd, p_wr, p_rd;
  logic [2:0] h_addr, p_addr;
  logic [7:0] h_wdata, p_wdata, h_rdata, p_rdata;
  logic       h_irq, p_irq, p_nmi, p_rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  mbox_bridge u_mbox_bridge (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .p_wr(p_wr), .p_rd(p_rd), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .h_irq(h_irq), .p_irq(p_irq), .p_nmi(p_nmi), .p_rst_n(p_rst_n));

  // behavioural model
  logic [7:0] h2p_q [4][$];
  logic [7:0] p2h_q [4][$];
  logic [7:0] last_h [4];
  logic [7:0] last_p [4];
  logic [5:0] ctl_m;

  function automatic int cap_of(int ch);
    return (ch == 2 && ctl_m[4]) ? 2 : 1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      h2p_q[c].delete();
      p2h_q[c].delete();
      last_h[c] = 8'h00;
      last_p[c] = 8'h00;
    end
    ctl_m = 6'b100000;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int hc = int'(h_addr[2:1]);
    int pc = int'(p_addr[2:1]);
    logic [7:0] eh, ep;
    if (h_addr[0]) begin
      eh = (p2h_q[hc].size() != 0) ? p2h_q[hc][0] : last_h[hc];
      chk("R1 R10 R11 R12 host data", h_rdata, eh);
    end else begin
      eh = {p2h_q[hc].size() != 0, h2p_q[hc].size() < cap_of(hc), (hc == 0) ? ctl_m : 6'b0};
      if (hc == 0) chk("R5 host control readback", h_rdata, eh);
      else         chk("R3 R4 host status", h_rdata, eh);
    end
    if (p_addr[0]) begin
      ep = (h2p_q[pc].size() != 0) ? h2p_q[pc][0] : last_p[pc];
      chk("R1 R10 R11 R12 parasite data", p_rdata, ep);
    end else begin
      ep = {h2p_q[pc].size() != 0, p2h_q[pc].size() < cap_of(pc), 6'b0};
      chk("R3 R4 parasite status", p_rdata, ep);
    end
    chk("R6 R8 p_irq", {7'b0, p_irq},
        {7'b0, (ctl_m[1] && h2p_q[0].size() != 0) || (ctl_m[2] && h2p_q[3].size() != 0)});
    chk("R7 p_nmi", {7'b0, p_nmi}, {7'b0, ctl_m[3] && h2p_q[2].size() != 0});
    chk("R9 h_irq", {7'b0, h_irq}, {7'b0, ctl_m[0] && p2h_q[3].size() != 0});
    chk("R13 p_rst_n", {7'b0, p_rst_n}, {7'b0, ctl_m[5]});
  endtask

  task automatic step(logic hw, logic hr, logic [2:0] ha, logic [7:0] hd,
                      logic pw, logic pr, logic [2:0] pa, logic [7:0] pd);
    int hc, pc;
    bit h_push, h_pop, p_push, p_pop, c_wr;
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    p_wr = pw; p_rd = pr; p_addr = pa; p_wdata = pd;
    #2;
    compare();
    @(posedge clk);
    hc = int'(ha[2:1]);
    pc = int'(pa[2:1]);
    h_push = hw && ha[0] && (h2p_q[hc].size() < cap_of(hc));
    h_pop  = hr && ha[0] && (p2h_q[hc].size() != 0);
    p_push = pw && pa[0] && (p2h_q[pc].size() < cap_of(pc));
    p_pop  = pr && pa[0] && (h2p_q[pc].size() != 0);
    c_wr   = hw && (ha == 3'd0);
    if (h_pop)  last_h[hc] = p2h_q[hc].pop_front();
    if (p_pop)  last_p[pc] = h2p_q[pc].pop_front();
    if (h_push) h2p_q[hc].push_back(hd);
    if (p_push) p2h_q[pc].push_back(pd);
    if (c_wr)   ctl_m = hd[5:0];
  endtask

  task automatic hwr(logic [2:0] a, logic [7:0] d); step(1, 0, a, d, 0, 0, 3'd0, 8'h0); endtask
  task automatic hrd(logic [2:0] a); step(0, 1, a, 8'h0, 0, 0, 3'd0, 8'h0); endtask
  task automatic pwr(logic [2:0] a, logic [7:0] d); step(0, 0, 3'd0, 8'h0, 1, 0, a, d); endtask
  task automatic prd(logic [2:0] a); step(0, 0, 3'd0, 8'h0, 0, 1, a, 8'h0); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
    p_wr = 0; p_rd = 0; p_addr = 0; p_wdata = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #2;
    chk("R2 host status1 reset", h_rdata, 8'h60);
    chk("R2 parasite status1 reset", p_rdata, 8'h40);
    chk("R2 p_rst_n reset", {7'b0, p_rst_n}, 8'h01);
    chk("R2 irq lines reset", {5'b0, h_irq, p_irq, p_nmi}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 3'd1, 8'h0, 0, 0, 3'd7, 8'h0);

    // R6: channel 1 IRQ, then full write ignored (R11), empty read (R12)
    hwr(3'd0, 8'h22);
    hwr(3'd1, 8'hA5);
    hwr(3'd1, 8'h5A);
    prd(3'd0);
    prd(3'd1);
    prd(3'd1);
    prd(3'd1);
    // R8 R9: channel 4 both ways
    hwr(3'd0, 8'h25);
    hwr(3'd7, 8'h44);
    pwr(3'd7, 8'h99);
    hrd(3'd6);
    hrd(3'd7);
    prd(3'd7);
    // R10 R7: channel 3 two-deep with NMI
    hwr(3'd0, 8'h38);
    hwr(3'd5, 8'h11);
    hwr(3'd5, 8'h22);
    hwr(3'd5, 8'h33);
    prd(3'd4);
    prd(3'd5);
    prd(3'd5);
    prd(3'd5);
    pwr(3'd5, 8'hC1);
    pwr(3'd5, 8'hC2);
    hrd(3'd5);
    hrd(3'd5);
    // channel 3 single-entry while deep bit clear
    hwr(3'd0, 8'h28);
    hwr(3'd5, 8'h66);
    hwr(3'd5, 8'h77);
    prd(3'd5);
    // R5: parasite writes to status ignored; R13 parasite held in reset
    pwr(3'd0, 8'hFF);
    pwr(3'd2, 8'hFF);
    hwr(3'd0, 8'h00);
    hrd(3'd0);
    hwr(3'd0, 8'h3F);

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ha = 3'($urandom);
      logic [2:0] pa = 3'($urandom);
      logic hw = ($urandom % 3) == 0;
      logic pw = ($urandom % 3) == 0;
      if (hw && ha == 3'd0 && ($urandom % 4) != 0) ha = 3'd5;
      step(hw, ($urandom % 3) == 0, ha, 8'($urandom),
           pw, ($urandom % 3) == 0, pa, 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule